// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block drives a linear image sensor and collects one digitized frame from it. It generates a free-running master clock with a 50% duty cycle. On request, it lowers the integration-clear gate and pulses the shift gate inside that low window. This moves the accumulated charge into the sensor's output register and starts a new exposure. The block then releases the clear gate on a master clock rising edge. From that edge on, it marks a pixel boundary on every second master clock rising edge.

At each pixel boundary the block raises a trigger strobe for the external converter. It accepts the first converted word that comes back on the parallel bus during that pixel slot, and tags the word with its position in the frame. Every frame transfers the whole sensor line, dummy cells included. All intervals are counted in system clock cycles and set by parameters. One parameter inverts the clock and gate pins so they can drive inverting buffers.

Top module: `lsq_sensor_seq`

## Requirements
- R1: After reset and between frames, the shift gate (`sh_o`) is low, the clear gate (`icg_o`) is high, and no trigger, capture or done pulse is raised (levels given for `INVERT`=0).
- R2: `mclk_o` runs freely, high for exactly `HALF_PER` cycles and then low for exactly `HALF_PER` cycles. A period starts with its high phase.
- R3: A frame starts with `icg_o` falling. `sh_o` rises exactly `T_PRE` cycles later and stays high for exactly `T_SH` cycles, all while `icg_o` is low.
- R4: `icg_o` rises at least `T_POST` and at most `T_POST`+2·`HALF_PER` cycles after `sh_o` falls. The rise lands in the same cycle as a rising edge of `mclk_o`.
- R5: `int_start` is a one-cycle pulse in the first cycle that `sh_o` is low after its high pulse, and at no other time.
- R6: `sample_trig` pulses in the cycle `icg_o` rises and then every 4·`HALF_PER` cycles, exactly `N_PIX` times per frame. Each pulse coincides with a rising edge of `mclk_o`.
- R7: A pixel slot covers the cycles after its trigger up to and including the cycle before the next boundary. The first `pix_valid` in a slot gives, one cycle later, `cap_valid` with that `pix_data` and the slot's 0-based index on `cap_index`. A `pix_valid` in the trigger cycle itself, or a later one in the same slot, is ignored.
- R8: `pix_valid` outside the pixel slots (idle, gate sequence, and the cycle that closes the last slot) produces no `cap_valid`.
- R9: `frame_done` is a one-cycle pulse 4·`HALF_PER`+1 cycles after the last trigger of a frame.
- R10: If `start_req` is seen in idle, `icg_o` falls in the next cycle. A request seen while a frame runs is held, and the next frame's `icg_o` falls in the cycle after `frame_done`. Several held requests give only one extra frame.
- R11: With `INVERT`=1, `mclk_o`, `icg_o` and `sh_o` are the exact complements of the `INVERT`=0 levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Frame request strobe |
| pix_valid | input | 1 | Converted pixel word present |
| pix_data | input | DATA_W | Converted pixel word |
| mclk_o | output | 1 | Sensor master clock |
| icg_o | output | 1 | Integration-clear gate |
| sh_o | output | 1 | Shift gate |
| sample_trig | output | 1 | Pixel boundary / converter start strobe |
| int_start | output | 1 | New exposure began (shift gate fell) |
| cap_valid | output | 1 | Captured pixel present |
| cap_data | output | DATA_W | Captured pixel word |
| cap_index | output | clog2(N_PIX+1) | Position of the captured pixel in the frame |
| frame_done | output | 1 | Frame finished |

## Verification
A stuck or skewed master clock divider shows up within one clock period as a wrong run length. A misaligned gate release shows up as a clear-gate edge that misses a clock rising edge, or as a first trigger in another cycle. An off-by-one in the pixel counter changes the trigger count or moves the done pulse by one slot at the end of the first frame. A slot flag that is wrong in the capture stage gives a missing, duplicated or mis-indexed capture within that same slot. The bench drives random valid patterns per slot and random words between frames, so these faults surface quickly.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SHH,
      ST_POST,
      ST_READ
   } seq_state_t;
endpackage

// File: rtl/lsq_mclk_gen.sv
module lsq_mclk_gen #(
   parameter int HALF_PER = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic mclk,
   output logic per_start,
   output logic per_next
);
   localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

   logic [CW-1:0] hcnt;
   logic          ph;   // 0: high phase, 1: low phase

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         ph   <= 1'b0;
      end else if (hcnt == LAST) begin
         hcnt <= '0;
         ph   <= ~ph;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   assign mclk      = ~ph;
   assign per_start = ~ph & (hcnt == '0);
   assign per_next  = ph & (hcnt == LAST);

   a_r2_flip_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt == LAST) |=> (mclk != $past(mclk)));
   a_r2_hold_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt != LAST) |=> $stable(mclk));
endmodule

// File: rtl/lsq_gate_fsm.sv
module lsq_gate_fsm
   import lsq_pkg::*;
#(
   parameter int HALF_PER = 4,
   parameter int T_PRE    = 32,
   parameter int T_SH     = 160,
   parameter int T_POST   = 160,
   parameter int N_PIX    = 1546,
   parameter int IW       = $clog2(N_PIX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          per_start,
   input  logic          per_next,
   output logic          icg,
   output logic          sh,
   output logic          int_start,
   output logic          trig,
   output logic          fin,
   output logic [IW-1:0] pix_idx,
   output logic          frame_done
);
   localparam int TMAX = (T_PRE > T_SH) ? ((T_PRE > T_POST) ? T_PRE : T_POST)
                                        : ((T_SH > T_POST) ? T_SH : T_POST);
   localparam int TW = $clog2(TMAX + 1);
   localparam logic [TW-1:0] PRE_END  = TW'(T_PRE - 1);
   localparam logic [TW-1:0] SH_END   = TW'(T_SH - 1);
   localparam logic [TW-1:0] POST_END = TW'(T_POST - 1);
   localparam logic [IW-1:0] LAST_BND = IW'(N_PIX);

   seq_state_t    st;
   logic [TW-1:0] tcnt;
   logic [IW-1:0] bcnt;
   logic          odd, pend, launch, bnd;

   assign launch  = (st == ST_IDLE) && (pend || start_req);
   assign bnd     = (st == ST_READ) && per_start && !odd;
   assign fin     = bnd && (bcnt == LAST_BND);
   assign trig    = bnd && (bcnt != LAST_BND);
   assign pix_idx = bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         tcnt       <= '0;
         bcnt       <= '0;
         odd        <= 1'b0;
         pend       <= 1'b0;
         icg        <= 1'b1;
         sh         <= 1'b0;
         int_start  <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         int_start  <= 1'b0;
         frame_done <= 1'b0;
         pend       <= (pend || start_req) && !launch;
         unique case (st)
            ST_IDLE: if (launch) begin
               st   <= ST_PRE;
               icg  <= 1'b0;
               tcnt <= '0;
            end
            ST_PRE: if (tcnt == PRE_END) begin
               st   <= ST_SHH;
               sh   <= 1'b1;
               tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
            ST_SHH: if (tcnt == SH_END) begin
               st        <= ST_POST;
               sh        <= 1'b0;
               int_start <= 1'b1;
               tcnt      <= '0;
            end else tcnt <= tcnt + 1'b1;
            ST_POST: if ((tcnt >= POST_END) && per_next) begin
               st   <= ST_READ;
               icg  <= 1'b1;
               bcnt <= '0;
               odd  <= 1'b0;
            end else if (tcnt < POST_END) tcnt <= tcnt + 1'b1;
            ST_READ: if (per_start) begin
               odd <= ~odd;
               if (fin) begin
                  st         <= ST_IDLE;
                  frame_done <= 1'b1;
               end else if (trig) bcnt <= bcnt + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r3_shift_inside_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sh |-> !icg);
   a_r5_event_on_shift_fall: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |-> (!sh && $past(sh)));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && start_req) |=> pend);
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_READ) |-> (bcnt <= LAST_BND));
endmodule

// File: rtl/lsq_capture.sv
module lsq_capture #(
   parameter int DATA_W = 8,
   parameter int IW     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              fin,
   input  logic [IW-1:0]     idx_in,
   input  logic              pix_valid,
   input  logic [DATA_W-1:0] pix_data,
   output logic              cap_valid,
   output logic [DATA_W-1:0] cap_data,
   output logic [IW-1:0]     cap_index
);
   logic          win, got;
   logic [IW-1:0] widx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win       <= 1'b0;
         got       <= 1'b0;
         widx      <= '0;
         cap_valid <= 1'b0;
         cap_data  <= '0;
         cap_index <= '0;
      end else begin
         cap_valid <= 1'b0;
         if (fin) begin
            win <= 1'b0;
         end else if (trig) begin
            win  <= 1'b1;
            got  <= 1'b0;
            widx <= idx_in;
         end else if (win && !got && pix_valid) begin
            got       <= 1'b1;
            cap_valid <= 1'b1;
            cap_data  <= pix_data;
            cap_index <= widx;
         end
      end
   end

   a_r7_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (got && !trig && !fin) |=> !cap_valid);
   a_r8_capture_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> $past(win));
endmodule

// File: rtl/lsq_sensor_seq.sv
module lsq_sensor_seq #(
   parameter int DATA_W   = 8,
   parameter int HALF_PER = 4,
   parameter int T_PRE    = 32,
   parameter int T_SH     = 160,
   parameter int T_POST   = 160,
   parameter int N_PIX    = 1546,
   parameter bit INVERT   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_req,
   input  logic                         pix_valid,
   input  logic [DATA_W-1:0]            pix_data,
   output logic                         mclk_o,
   output logic                         icg_o,
   output logic                         sh_o,
   output logic                         sample_trig,
   output logic                         int_start,
   output logic                         cap_valid,
   output logic [DATA_W-1:0]            cap_data,
   output logic [$clog2(N_PIX+1)-1:0]   cap_index,
   output logic                         frame_done
);
   localparam int IW = $clog2(N_PIX + 1);

   if (HALF_PER < 1 || T_PRE < 1 || T_SH < 1 || T_POST < 1) begin : g_bad_time
      $error("lsq_sensor_seq: all interval parameters must be at least 1");
   end
   if (N_PIX < 2 || DATA_W < 1) begin : g_bad_size
      $error("lsq_sensor_seq: N_PIX must be >= 2 and DATA_W >= 1");
   end

   logic mclk_raw, per_start, per_next;
   logic icg_raw, sh_raw, trig, fin;
   logic [IW-1:0] pix_idx;

   lsq_mclk_gen #(.HALF_PER(HALF_PER)) u_mclk (
      .clk(clk), .rst_n(rst_n),
      .mclk(mclk_raw), .per_start(per_start), .per_next(per_next)
   );

   lsq_gate_fsm #(
      .HALF_PER(HALF_PER), .T_PRE(T_PRE), .T_SH(T_SH), .T_POST(T_POST),
      .N_PIX(N_PIX), .IW(IW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .per_start(per_start), .per_next(per_next),
      .icg(icg_raw), .sh(sh_raw), .int_start(int_start),
      .trig(trig), .fin(fin), .pix_idx(pix_idx), .frame_done(frame_done)
   );

   lsq_capture #(.DATA_W(DATA_W), .IW(IW)) u_cap (
      .clk(clk), .rst_n(rst_n), .trig(trig), .fin(fin), .idx_in(pix_idx),
      .pix_valid(pix_valid), .pix_data(pix_data),
      .cap_valid(cap_valid), .cap_data(cap_data), .cap_index(cap_index)
   );

   assign sample_trig = trig;

   if (INVERT) begin : g_pol_inv
      assign mclk_o = ~mclk_raw;
      assign icg_o  = ~icg_raw;
      assign sh_o   = ~sh_raw;
   end else begin : g_pol_true
      assign mclk_o = mclk_raw;
      assign icg_o  = icg_raw;
      assign sh_o   = sh_raw;
   end

   a_r4_release_on_clock_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(icg_raw) |-> $rose(mclk_raw));
   a_r6_trig_on_clock_rise: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $rose(mclk_raw));
   a_r6_first_trig_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(icg_raw) |-> trig);
endmodule

// File: tb/lsq_sensor_seq_tb.sv
module lsq_sensor_seq_tb;
   localparam int H     = 2;
   localparam int TPRE  = 3;
   localparam int TSH   = 6;
   localparam int TPOST = 5;
   localparam int NPIX  = 24;
   localparam int SLOT  = 4 * H;
   localparam int IW    = $clog2(NPIX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic pix_valid = 1'b0;
   logic [7:0] pix_data = '0;
   logic mclk_o, icg_o, sh_o, sample_trig, int_start, cap_valid, frame_done;
   logic [7:0] cap_data;
   logic [IW-1:0] cap_index;
   logic i_mclk, i_icg, i_sh, i_trig, i_ist, i_cv, i_done;
   logic [7:0] i_cd;
   logic [IW-1:0] i_ci;

   always #4 clk = ~clk;

   lsq_sensor_seq #(.DATA_W(8), .HALF_PER(H), .T_PRE(TPRE), .T_SH(TSH),
      .T_POST(TPOST), .N_PIX(NPIX), .INVERT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .pix_valid(pix_valid),
      .pix_data(pix_data), .mclk_o(mclk_o), .icg_o(icg_o), .sh_o(sh_o),
      .sample_trig(sample_trig), .int_start(int_start), .cap_valid(cap_valid),
      .cap_data(cap_data), .cap_index(cap_index), .frame_done(frame_done));

   lsq_sensor_seq #(.DATA_W(8), .HALF_PER(H), .T_PRE(TPRE), .T_SH(TSH),
      .T_POST(TPOST), .N_PIX(NPIX), .INVERT(1'b1)) u_inv (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .pix_valid(pix_valid),
      .pix_data(pix_data), .mclk_o(i_mclk), .icg_o(i_icg), .sh_o(i_sh),
      .sample_trig(i_trig), .int_start(i_ist), .cap_valid(i_cv),
      .cap_data(i_cd), .cap_index(i_ci), .frame_done(i_done));

   int nchk = 0, nfail = 0, cyc = 0;
   int exp_launch = -1, t_icgf = 0, t_shr = 0, t_shf = 0, last_trig = 0;
   int trig_cnt = 0, done_cnt = 0, off = 99, run = 0, inv_bad = 0;
   int exp_cap_cyc = -1, exp_i = 0;
   logic [7:0] exp_d;
   logic [SLOT-1:0] mask;
   logic [7:0] wdat [SLOT];
   bit req_busy = 0;
   logic p_mclk, p_icg, p_sh, p_done;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         check(0, "watchdog", cyc, 20000);
         summary();
      end
   end

   // monitor, reference model and pixel-bus driver
   always @(negedge clk) begin
      if (rst_n) begin
         if (i_mclk !== ~mclk_o || i_icg !== ~icg_o || i_sh !== ~sh_o) inv_bad++;
         // R2 run lengths of the master clock
         if (mclk_o != p_mclk) begin
            if (run > 0) check(run == H, "R2 mclk phase length", run, H);
            run = 1;
         end else if (run > 0) run++;
         // R7 / R8 capture outputs
         if (exp_cap_cyc == cyc) begin
            check(cap_valid === 1'b1, "R7 capture present", cap_valid, 1);
            check(cap_data == exp_d, "R7 capture data", cap_data, exp_d);
            check(cap_index == exp_i, "R7 capture index", cap_index, exp_i);
            exp_cap_cyc = -1;
         end else if (cap_valid) begin
            check(0, "R8 unexpected capture", cap_index, -1);
         end
         // R10 / R3 gate timing
         if (p_icg && !icg_o) begin
            check(exp_launch == cyc, "R10 frame launch cycle", cyc, exp_launch);
            exp_launch = -1;
            t_icgf = cyc;
         end else if (exp_launch != -1 && cyc > exp_launch) begin
            check(0, "R10 missing launch", cyc, exp_launch);
            exp_launch = -1;
         end
         if (!p_sh && sh_o) begin
            check(cyc - t_icgf == TPRE && !icg_o, "R3 clear-to-shift delay", cyc - t_icgf, TPRE);
            t_shr = cyc;
         end
         if (p_sh && !sh_o) begin
            check(cyc - t_shr == TSH, "R3 shift width", cyc - t_shr, TSH);
            t_shf = cyc;
         end
         if (int_start || (p_sh && !sh_o))
            check(int_start && p_sh && !sh_o, "R5 integration event", int_start, p_sh & ~sh_o);
         if (!p_icg && icg_o) begin
            check((cyc - t_shf >= TPOST) && (cyc - t_shf <= TPOST + 2*H),
                  "R4 shift-to-release gap", cyc - t_shf, TPOST);
            check(mclk_o && !p_mclk, "R4 release on clock rise", mclk_o, 1);
            check(sample_trig === 1'b1, "R6 first trigger at release", sample_trig, 1);
         end
         if (sample_trig) begin
            check(mclk_o && !p_mclk, "R6 trigger on clock rise", mclk_o, 1);
            if (trig_cnt > 0) check(cyc - last_trig == SLOT, "R6 trigger spacing", cyc - last_trig, SLOT);
            last_trig = cyc;
            // plan the valid pattern of this slot
            mask = SLOT'($urandom);
            for (int d = 0; d < SLOT; d++) wdat[d] = 8'($urandom);
            for (int d = SLOT - 1; d >= 1; d--)
               if (mask[d]) begin
                  exp_cap_cyc = cyc + d + 1;
                  exp_d = wdat[d];
                  exp_i = trig_cnt;
               end
            trig_cnt++;
            off = 0;
         end
         if (frame_done) begin
            check(!p_done, "R9 done width", p_done, 0);
            check(trig_cnt == NPIX, "R6 triggers per frame", trig_cnt, NPIX);
            check(cyc == last_trig + SLOT + 1, "R9 done timing", cyc, last_trig + SLOT + 1);
            check(icg_o && !sh_o, "R1 gate levels after frame", {icg_o, sh_o}, 2);
            done_cnt++;
            trig_cnt = 0;
            if (req_busy) begin
               exp_launch = cyc + 1;
               req_busy = 0;
            end
         end
         // drive the pixel bus for the next edge
         if (off < SLOT) begin
            pix_valid = mask[off];
            pix_data  = wdat[off];
            off++;
         end else begin
            pix_valid = 1'($urandom);
            pix_data  = 8'($urandom);
         end
      end
      p_mclk = mclk_o; p_icg = icg_o; p_sh = sh_o; p_done = frame_done;
   end

   task automatic req_idle(input int hold);
      @(negedge clk);
      start_req = 1'b1;
      exp_launch = cyc + 1;
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         req_busy = 1;     // later cycles of the request arrive while busy
      end
      @(negedge clk);
      start_req = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240613));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(icg_o === 1'b1, "R1 reset clear gate", icg_o, 1);
      check(sh_o === 1'b0, "R1 reset shift gate", sh_o, 0);
      check(cap_valid === 1'b0 && sample_trig === 1'b0, "R1 reset strobes", cap_valid, 0);
      check(frame_done === 1'b0 && int_start === 1'b0, "R1 reset events", frame_done, 0);
      repeat (20) @(negedge clk);   // random bus traffic in idle (R8)

      req_idle(1);
      while (done_cnt < 1) @(negedge clk);
      repeat (10) @(negedge clk);

      // R10: two requests while a frame runs collapse into one extra frame
      req_idle(1);
      while (trig_cnt < 5) @(negedge clk);
      start_req = 1'b1; req_busy = 1;
      @(negedge clk); start_req = 1'b0;
      repeat (7) @(negedge clk);
      start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
      while (done_cnt < 3) @(negedge clk);
      repeat (60) @(negedge clk);
      check(done_cnt == 3, "R10 single extra frame", done_cnt, 3);

      // R10: a two-cycle request from idle yields two frames
      req_idle(2);
      while (done_cnt < 5) @(negedge clk);
      repeat (40) @(negedge clk);
      check(done_cnt == 5, "R10 held request frame count", done_cnt, 5);
      check(icg_o && !sh_o, "R1 final idle levels", {icg_o, sh_o}, 2);
      check(inv_bad == 0, "R11 inverted outputs", inv_bad, 0);
      summary();
   end
endmodule